// File: doc/BRIEF.md
# Bit-Serial Shift-Add Multiplier

This block is a small-area 32x32 integer multiplier for a compact processor core. It looks at one bit of operand B per clock and owns no adder of its own. In each cycle it drives two addends onto output ports, and an adder outside the block returns their sum in that same cycle. Each request asks for either the low or the high 32 bits of the 64-bit product. A two-bit mode says, for each operand, whether it is signed.

Low-word requests move up B from its least significant bit, adding a left-shifted copy of A into the accumulator. They stop as soon as the B bits still to be consumed are all zero, so a small B gives a short latency. High-word requests always run through all 32 rows, because every row affects the upper word. Signed rows use inverted sign bits instead of sign extension. One extra cycle then adds the correction constant, which gives 33 cycles in all.

The surrounding pipeline raises the enable and holds it, with the operator, mode and operands unchanged, until the one-cycle valid pulse appears. If the enable drops before that, the block abandons the operation.

Top module: `bitserial_mul`

## Requirements
- R1: A low-word request (`op_high`=0) returns bits [31:0] of the product, whatever the value of `sign_mode`.
- R2: A high-word request (`op_high`=1) returns bits [63:32] of the 64-bit product. `sign_mode[0]`=1 makes A signed and `sign_mode[1]`=1 makes B signed; 2'b00 means both operands are unsigned.
- R3: A low-word request raises `valid` in cycle n of the request, counting the first enabled cycle as 1. Here n is one more than the index of the highest set bit of B, and n is 1 when B is zero.
- R4: A high-word request raises `valid` in cycle 33, and never before.
- R5: A low-word request with B equal to zero completes in its first cycle with a zero result.
- R6: Every addition goes through the adder ports. In the first cycle of a request `add_x` is zero, and `result` is the low 32 bits of `add_sum`.
- R7: `valid` is a single-cycle pulse and is never high while `en` is low. After the valid cycle the block is idle.
- R8: Dropping `en` before completion returns the block to idle. The next request then has its normal latency and result.
- R9: After reset the block is idle, with `valid` low and `add_x` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Request active; held high until valid |
| op_high | input | 1 | 1: high product word, 0: low product word |
| sign_mode | input | 2 | Bit 0: A signed, bit 1: B signed |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| add_x | output | 34 | First addend to the external adder |
| add_y | output | 34 | Second addend to the external adder |
| add_sum | input | 34 | Sum returned by the external adder, same cycle |
| valid | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product word, meaningful while valid is high |

## Verification
Some properties are checked on every cycle. These are: the return to idle after a valid pulse or a dropped enable; a single-cycle pulse for high-word completions; completion of high-word requests only while busy; and the one-cycle completions for B of zero and one, where the result must be zero and A respectively. Other behaviour only the bench's scenarios can show. This covers exact latencies that depend on B's leading bit, the signed upper-word arithmetic in all four modes against a 64-bit reference, and recovery after an abandoned request.

// File: rtl/bitserial_mul.sv
module bitserial_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         op_high,
  input  logic [1:0]   sign_mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W+1:0] add_x,
  output logic [W+1:0] add_y,
  input  logic [W+1:0] add_sum,
  output logic         valid,
  output logic [W-1:0] result
);

  localparam int CW = $clog2(W + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W:0]    acc;
  logic [W-1:0]  lo;
  logic [W-1:0]  a_sh;

  logic [CW-1:0] step;
  logic [W-1:0]  lo_cur;
  logic [W-1:0]  a_cur;
  logic          bit_cur;
  logic          sa;
  logic          neg_row;
  logic [W:0]    row;
  logic [W:0]    biased;
  logic          fix_step;
  logic          fix_bit;
  logic          low_done;

  assign step     = busy ? cnt : '0;
  assign lo_cur   = busy ? lo : opb;
  assign a_cur    = busy ? a_sh : opa;
  assign bit_cur  = lo_cur[0];
  assign sa       = sign_mode[0] & opa[W-1];
  assign row      = bit_cur ? {sa, opa} : '0;
  // last row carries negative weight when B is signed: invert, fix the missing +1 later
  assign neg_row  = sign_mode[1] && (step == CW'(W - 1));
  assign biased   = neg_row ? {row[W], ~row[W-1:0]} : {~row[W], row[W-1:0]};
  assign fix_step = busy && (cnt == CW'(W));
  assign fix_bit  = sign_mode[1] & lo[W-1];
  assign low_done = (lo_cur[W-1:1] == '0);

  assign add_x = busy ? {1'b0, acc} : '0;

  always_comb begin
    if (op_high) begin
      if (fix_step) add_y = {{W{1'b0}}, fix_bit, ~fix_bit};
      else          add_y = {1'b0, biased};
    end else begin
      add_y = bit_cur ? {2'b00, a_cur} : '0;
    end
  end

  assign valid  = en & (op_high ? fix_step : low_done);
  assign result = add_sum[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      lo   <= '0;
      a_sh <= '0;
    end else if (!en || valid) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= 1'b1;
      cnt  <= step + CW'(1);
      if (op_high) begin
        acc <= add_sum[W+1:1];
        lo  <= {add_sum[0], lo_cur[W-1:1]};
      end else begin
        acc  <= {1'b0, add_sum[W-1:0]};
        lo   <= {1'b0, lo_cur[W-1:1]};
        a_sh <= {a_cur[W-2:0], 1'b0};
      end
    end
  end

  p_idle_after_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !busy);

  p_high_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op_high) |=> !valid);

  p_abort_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && cnt == '0));

  p_zero_b_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy && !op_high && opb == '0) |-> (valid && result == '0));

  p_unit_b_gives_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy && !op_high && opb == W'(1)) |-> (valid && result == opa));

  p_high_done_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op_high) |-> (busy && $past(busy)));

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= CW'(W)));

endmodule

// File: tb/bitserial_mul_bench.sv
module bitserial_mul_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         op_high = 1'b0;
  logic [1:0]   sign_mode = 2'b00;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W+1:0] add_x, add_y, add_sum;
  logic         valid;
  logic [W-1:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  // external adder model
  assign add_sum = add_x + add_y;

  bitserial_mul #(.W(W)) u_bitserial_mul (
    .clk(clk), .rst_n(rst_n), .en(en), .op_high(op_high), .sign_mode(sign_mode),
    .opa(opa), .opb(opb), .add_x(add_x), .add_y(add_y), .add_sum(add_sum),
    .valid(valid), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    logic signed [65:0] ea, eb, p;
    ea = m[0] ? {{34{a[31]}}, a} : {34'b0, a};
    eb = m[1] ? {{34{b[31]}}, b} : {34'b0, b};
    p  = ea * eb;
    return p[63:0];
  endfunction

  function automatic int low_lat(input logic [31:0] b);
    int n = 1;
    for (int i = 0; i < 32; i++) if (b[i]) n = i + 1;
    return n;
  endfunction

  task automatic run_op(input bit hi, input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    int lat;
    logic [63:0] p;
    logic [31:0] exp;
    string lt, rt;
    lat = hi ? 33 : low_lat(b);
    p   = ref_prod(m, a, b);
    exp = hi ? p[63:32] : p[31:0];
    lt  = hi ? "R4 latency" : ((b == 0) ? "R5 zero-b latency" : "R3 latency");
    rt  = hi ? "R2 high word" : ((b == 0) ? "R5 zero-b result" : "R1 low word");
    @(negedge clk);
    en = 1'b1; op_high = hi; sign_mode = m; opa = a; opb = b;
    for (int c = 1; c <= lat; c++) begin
      #5;
      if (c == 1) chk(add_x == '0, "R6 first addend zero", 64'(add_x), 64'd0);
      if (c < lat) chk(valid == 1'b0, lt, 64'(valid), 64'd0);
      else begin
        chk(valid == 1'b1, lt, 64'(valid), 64'd1);
        chk(result == exp, rt, 64'(result), 64'(exp));
      end
      @(negedge clk);
    end
    en = 1'b0;
    #5 chk(valid == 1'b0, "R7 no valid without enable", 64'(valid), 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] corners [5];
    logic [31:0] s;
    logic [31:0] ra, rb;
    corners = '{32'h0, 32'h1, 32'hffffffff, 32'h80000000, 32'h7fffffff};
    s = 32'h1234_5678;

    repeat (3) @(negedge clk);
    #5;
    chk(valid == 1'b0, "R9 reset valid low", 64'(valid), 64'd0);
    chk(add_x == '0, "R9 reset idle addend", 64'(add_x), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          run_op(1'b1, 2'(m), corners[i], corners[j]);
          run_op(1'b0, 2'(m), corners[i], corners[j]);
        end

    for (int k = 0; k < 60; k++) begin
      s = s * 32'd1664525 + 32'd1013904223; ra = s;
      s = s * 32'd1664525 + 32'd1013904223; rb = s;
      s = s * 32'd1664525 + 32'd1013904223;
      run_op(1'b1, 2'(k % 4), ra, rb);
      run_op(1'b0, 2'(k % 4), ra, rb >> (s[4:0]));
    end

    // R8: abandon a high-word request mid-way, then confirm fresh requests behave normally
    @(negedge clk);
    en = 1'b1; op_high = 1'b1; sign_mode = 2'b11; opa = 32'hdead_beef; opb = 32'h8000_0001;
    for (int c = 0; c < 10; c++) begin
      #5 chk(valid == 1'b0, "R8 no valid before abort", 64'(valid), 64'd0);
      @(negedge clk);
    end
    en = 1'b0;
    #5 chk(valid == 1'b0, "R8 idle after abort", 64'(valid), 64'd0);
    run_op(1'b0, 2'b00, 32'h0000_0007, 32'h0000_0005);
    run_op(1'b1, 2'b01, 32'h8000_0000, 32'hffff_ffff);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule